// File: doc/BRIEF.md
# Evenly Spread One-Bit Density Modulator

This block turns a duty setting into a single-bit stream whose long-run average is the duty divided by a programmable cycle length. The cycle length does not have to be a power of two. The block does not emit one solid pulse per cycle. It holds a signed error accumulator and emits a one each time the accumulated duty turns positive. The ones are therefore interleaved through the cycle as evenly as the ratio allows, which moves the ripple to a higher frequency where a simple external filter can remove it.

On each clock the block adds the clamped duty to the accumulator. When the sum is strictly above zero, it emits a one and subtracts the cycle length in the same clock. Otherwise it emits a zero and keeps the sum. Before the addition, the accumulator is raised to the floor of the current cycle length. This means a shorter cycle length written on the fly takes effect on the next clock and does not first drain a deficit left from the old setting.

Top module: `pdm_modulator`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pdm_o` is 0 after that edge and the error accumulator is cleared to zero.
- R2: A duty of 0 gives `pdm_o` = 0 from the first clock that uses it, and on every clock after it.
- R3: A duty equal to or greater than a nonzero cycle length is clamped to the cycle length. It gives `pdm_o` = 1 from the first clock that uses it, and on every clock after it.
- R4: With duty and cycle length held, every window of N consecutive outputs after the change contains exactly min(duty, N) ones.
- R5: With duty and cycle length held, every window of k consecutive outputs (1 <= k <= N) contains c ones with |N*c - k*D| < N, where D is the clamped duty. The ones are spread, not grouped.
- R6: Cycle lengths that are not powers of two are handled exactly. A cycle length of 0 gives a constant 0 output.
- R7: With the accumulator cleared by reset, the first output after reset is 1 exactly when the clamped duty is nonzero.
- R8: The accumulator stays within -(2^W - 1) to 0 at all times, so the sum never overflows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| duty_i | input | W | Duty setting, unsigned, clamped to the cycle length |
| period_i | input | W | Cycle length N in clocks, unsigned |
| pdm_o | output | 1 | Registered one-bit density output |

## Verification
The bench goes after the edges of the duty range. A duty of zero must never produce a one, which catches a design that treats a zero sum as firing. A full or oversized duty must produce ones at once, which catches a missing clamp, because an unclamped duty would drive the accumulator upward and wrap it. When the cycle length shrinks abruptly, the output must follow on the next clock, and a design without the accumulator floor would emit a run of zeros before it recovered. The bench checks sliding-window counts of every length up to N on odd cycle lengths. This exposes any off-by-one in the subtraction or a clumped pulse. The first bit after reset is also checked, which exposes an accumulator that reset does not clear.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

    parameter int unsigned PDM_DEFAULT_W = 8;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } pdm_level_e;

endpackage

// File: rtl/pdm_duty_clamp.sv
module pdm_duty_clamp #(
    parameter int unsigned W = pdm_pkg::PDM_DEFAULT_W
) (
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] period_i,
    output logic [W-1:0] duty_o
);
    logic saturate;

    always_comb begin
        saturate = (duty_i >= period_i);
        duty_o   = saturate ? period_i : duty_i;
    end

endmodule

// File: rtl/pdm_err_accum.sv
module pdm_err_accum
    import pdm_pkg::*;
#(
    parameter int unsigned W = PDM_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] period_i,
    output pdm_level_e   level_o
);
    localparam int unsigned AW = W + 2;

    typedef struct packed {
        logic signed [AW-1:0] acc;
        pdm_level_e           level;
    } step_t;

    step_t                state_q;
    step_t                state_d;
    logic signed [AW-1:0] duty_s;
    logic signed [AW-1:0] period_s;
    logic signed [AW-1:0] floor_s;
    logic signed [AW-1:0] acc_eff;
    logic signed [AW-1:0] sum;

    always_comb begin
        duty_s   = $signed({2'b00, duty_i});
        period_s = $signed({2'b00, period_i});
        // lowest value the accumulator may hold for the present cycle length
        floor_s  = (period_i == '0) ? '0 : (AW'(1) - period_s);
        acc_eff  = (state_q.acc < floor_s) ? floor_s : state_q.acc;
        sum      = acc_eff + duty_s;
        if (sum > 0) begin
            state_d.acc   = sum - period_s;
            state_d.level = LVL_HIGH;
        end else begin
            state_d.acc   = sum;
            state_d.level = LVL_LOW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.acc   <= '0;
            state_q.level <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    assign level_o = state_q.level;

    // R1: reset leaves a low output and a cleared accumulator
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state_q.level == LVL_LOW) && (state_q.acc == '0));

    // R2: zero duty never fires
    p_zero_duty_r2: assert property (@(posedge clk) disable iff (rst)
        (duty_i == '0) |=> (level_o == LVL_LOW));

    // R3: full duty always fires
    p_full_duty_r3: assert property (@(posedge clk) disable iff (rst)
        ((duty_i == period_i) && (period_i != '0)) |=> (level_o == LVL_HIGH));

    // R8: accumulator range
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q.acc <= 0) && (state_q.acc >= -$signed({2'b00, {W{1'b1}}})));

endmodule

// File: rtl/pdm_modulator.sv
module pdm_modulator
    import pdm_pkg::*;
#(
    parameter int unsigned W = PDM_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] duty_i,
    input  logic [W-1:0] period_i,
    output logic         pdm_o
);
    logic [W-1:0] duty_clamped;
    pdm_level_e   level;

    pdm_duty_clamp #(.W(W)) clamp_i (
        .duty_i   (duty_i),
        .period_i (period_i),
        .duty_o   (duty_clamped)
    );

    pdm_err_accum #(.W(W)) accum_i (
        .clk      (clk),
        .rst      (rst),
        .duty_i   (duty_clamped),
        .period_i (period_i),
        .level_o  (level)
    );

    assign pdm_o = (level == LVL_HIGH);

    // R3: an oversized duty behaves as a full duty
    p_clamp_full_r3: assert property (@(posedge clk) disable iff (rst)
        ((duty_i > period_i) && (period_i != '0)) |=> pdm_o);

endmodule

// File: tb/pdm_modulator_tb.sv
module pdm_modulator_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] duty = '0;
    logic [W-1:0] period = '0;
    logic         pdm_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit hist [0:511];
    int hlen;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pdm_modulator #(.W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .duty_i   (duty),
        .period_i (period),
        .pdm_o    (pdm_o)
    );

    function automatic int clamp_duty(int v, int n);
        return (v > n) ? n : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int window_ones(int k);
        int c = 0;
        for (int j = hlen - k; j < hlen; j++) c += hist[j];
        return c;
    endfunction

    // Run one segment with held settings; optionally preceded by a reset.
    task automatic segment(int v, int n, int len, bit with_reset);
        int d = clamp_duty(v, n);
        hlen = 0;
        if (with_reset) begin
            rst = 1'b1;
            duty = W'(v);
            period = W'(n);
            @(negedge clk);
            check(pdm_o == 1'b0, "R1 reset output", pdm_o, 0);
            rst = 1'b0;
        end else begin
            duty = W'(v);
            period = W'(n);
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            hist[hlen] = pdm_o;
            hlen++;
            if (i == 0 && with_reset)
                check(pdm_o == (d > 0), "R7 first bit after reset", pdm_o, d > 0);
            if (d == 0)
                check(pdm_o == 1'b0, (n == 0) ? "R6 zero length" : "R2 zero duty", pdm_o, 0);
            if (n > 0 && d == n)
                check(pdm_o == 1'b1, "R3 full duty", pdm_o, 1);
            if (n > 0 && hlen >= n) begin
                int c = window_ones(n);
                check(c == d, "R4 window count", c, d);
                for (int k = 1; k <= n; k++) begin
                    int ck = window_ones(k);
                    int dev = n * ck - k * d;
                    if (dev < 0) dev = -dev;
                    if (dev >= n) begin
                        check(1'b0, "R5 spread", ck, (k * d) / n);
                        break;
                    end
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd5150));
        @(negedge clk);
        @(negedge clk);
        check(pdm_o == 1'b0, "R1 reset state", pdm_o, 0);
        // directed corners
        segment(1, 3, 12, 1'b1);
        segment(0, 7, 10, 1'b1);
        segment(7, 7, 10, 1'b0);
        segment(200, 13, 30, 1'b0);   // R3 clamp
        segment(5, 0, 8, 1'b0);       // R6 zero length
        segment(6, 13, 40, 1'b1);     // R6 odd length
        segment(39, 40, 90, 1'b0);
        segment(3, 5, 15, 1'b0);      // abrupt shrink
        segment(5, 5, 6, 1'b0);
        segment(0, 255, 20, 1'b0);
        segment(1, 255, 260, 1'b1);
        segment(254, 255, 260, 1'b0);
        // random segments
        for (int r = 0; r < 60; r++) begin
            int n = 1 + ($urandom % 40);
            int v = $urandom % (n + 6);
            segment(v, n, 3 * n + 5, ($urandom % 3) == 0);
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule